// File: doc/BRIEF.md
# SDRAM Access Command Sequencer

The sequencer takes one read or write request at a time from a user port and turns it into the commands an SDRAM expects on its command and address bus. Each request names a bank, a row and a starting column. When the bank has no open row, the block opens the row before it sends the column command. When a different row is open in that bank, it closes that row first. When the requested row is already open, the column command goes out straight away. Back-to-back hits to one open row therefore give one column command per clock.

A small table records, for each of the four banks, whether a row is open and which row it is. Each bank also has its own pair of spacing timers. An auto-precharge request closes the bank on its own clock. While that bank waits out its precharge time, the other banks stay fully usable. All spacings are parameters counted in clocks. Commands leave a register, so they are stable when the device samples them on the rising edge.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, cmd_o is NOP, req_ready is high and no bank counts as open, so the first request to any bank opens its row without a close command.
- R2: cmd_o carries {RAS#, CAS#, WE#}: NOP = 3'b111, ACTIVE = 3'b011, READ = 3'b101, WRITE = 3'b100, PRECHARGE = 3'b010. cmd_bank_o carries the bank of every non-NOP command.
- R3: For a request to a bank with no open row, ACTIVE appears with the row on cmd_addr_o[12:0]. The READ (req_we=0) or WRITE (req_we=1) follows exactly T_RCD cycles later, with the column on cmd_addr_o[9:0], cmd_addr_o[10] equal to req_ap, and cmd_addr_o[12:11] zero.
- R4: A request to the row already open in its bank produces only the column command, one cycle after acceptance. Consecutive hits give a column command on every cycle.
- R5: A request to a bank holding a different row produces PRECHARGE with cmd_addr_o all zero, one cycle after acceptance. ACTIVE follows T_RP cycles later, and the column command T_RCD cycles after that.
- R6: A column command with cmd_addr_o[10]=1 closes its bank. The next access to that bank starts with ACTIVE and no PRECHARGE, no earlier than T_APRE cycles after the column command.
- R7: While one bank waits out its precharge time, a request that hits an open row in another bank issues its column command one cycle after acceptance.
- R8: Every cycle without a scheduled command shows NOP on cmd_o.
- R9: req_ready is high when no request is pending, or when the pending request issues its column command in that cycle. Otherwise it is low, so the next request is accepted on the clock on which the previous request's column command appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request is taken on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the row automatically after this access |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Starting column |
| cmd_o | output | 3 | Registered {RAS#, CAS#, WE#} command |
| cmd_bank_o | output | 2 | Registered bank address |
| cmd_addr_o | output | 13 | Registered row, or column with auto-precharge flag on bit 10 |

## Verification
A wrong entry in the open-row table shows up on the bus within two clocks of the next request to that bank. A stale open flag sends a column command with no preceding ACTIVE. A lost flag sends an extra ACTIVE into an open bank, or skips the needed PRECHARGE. A wrong timer value moves the column command or the ACTIVE off its expected cycle. The scoreboard compares every non-NOP command with its exact cycle, so either error fails on the first affected command. A wrong ready or pending state moves the acceptance clock, and the bench checks that clock for every request.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);
    localparam int ROW_W  = 13;
    localparam int COL_W  = 10;
    localparam int AP_BIT = 10;

    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010
    } cmd_e;

    typedef struct packed {
        logic              we;
        logic              ap;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } req_t;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  addr;
    } bus_t;

    function automatic logic [ROW_W-1:0] col_addr(input logic [COL_W-1:0] c,
                                                  input logic ap);
        logic [ROW_W-1:0] r;
        r = '0;
        r[COL_W-1:0] = c;
        r[AP_BIT] = ap;
        return r;
    endfunction

    function automatic bit is_col(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/sdq_bank_table.sv
module sdq_bank_table
    import sdq_pkg::*;
#(
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_APRE = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ev_act,
    input  logic                         ev_pre,
    input  logic                         ev_close_ap,
    input  logic [BANK_W-1:0]            ev_bank,
    input  logic [ROW_W-1:0]             ev_row,
    output logic [NBANK-1:0]             open_o,
    output logic [NBANK-1:0][ROW_W-1:0]  row_o,
    output logic [NBANK-1:0]             rcd_ok_o,
    output logic [NBANK-1:0]             pre_ok_o
);

    localparam int TMAX = (T_RCD > T_RP) ? ((T_RCD > T_APRE) ? T_RCD : T_APRE)
                                         : ((T_RP > T_APRE) ? T_RP : T_APRE);
    localparam int CW = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LD_RCD  = CW'(T_RCD - 1);
    localparam logic [CW-1:0] LD_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] LD_APRE = CW'(T_APRE - 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        logic [CW-1:0]    rcd_q;
        logic [CW-1:0]    pre_q;
        logic             sel;

        assign sel = (ev_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q <= 1'b0;
                row_q  <= '0;
                rcd_q  <= '0;
                pre_q  <= '0;
            end else begin
                if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
                if (pre_q != '0) pre_q <= pre_q - 1'b1;
                if (sel && ev_act) begin
                    open_q <= 1'b1;
                    row_q  <= ev_row;
                    rcd_q  <= LD_RCD;
                end
                if (sel && ev_pre) begin
                    open_q <= 1'b0;
                    pre_q  <= LD_RP;
                end
                if (sel && ev_close_ap) begin
                    open_q <= 1'b0;
                    pre_q  <= LD_APRE;
                end
            end
        end

        assign open_o[b]   = open_q;
        assign row_o[b]    = row_q;
        assign rcd_ok_o[b] = (rcd_q == '0);
        assign pre_ok_o[b] = (pre_q == '0);

        // R3 / R6: a row may only be opened in a closed bank whose precharge time has run out
        p_act_when_free_r3: assert property (@(posedge clk) disable iff (rst)
            (sel && ev_act) |-> (!open_q && pre_q == '0));

        // R5: a bank is only closed while it holds a row
        p_pre_only_open_r5: assert property (@(posedge clk) disable iff (rst)
            (sel && ev_pre) |-> open_q);
    end

endmodule

// File: rtl/sdq_cmd_pick.sv
module sdq_cmd_pick
    import sdq_pkg::*;
(
    input  logic                         pend_v,
    input  req_t                         pend,
    input  logic [NBANK-1:0]             open_i,
    input  logic [NBANK-1:0][ROW_W-1:0]  row_i,
    input  logic [NBANK-1:0]             rcd_ok_i,
    input  logic [NBANK-1:0]             pre_ok_i,
    output bus_t                         nxt_o,
    output logic                         done_o
);

    logic [BANK_W-1:0] b;
    assign b = pend.bank;

    always_comb begin
        nxt_o.cmd  = CMD_NOP;
        nxt_o.bank = '0;
        nxt_o.addr = '0;
        done_o     = 1'b0;
        if (pend_v) begin
            if (open_i[b]) begin
                if (row_i[b] == pend.row) begin
                    if (rcd_ok_i[b]) begin
                        nxt_o.cmd  = pend.we ? CMD_WR : CMD_RD;
                        nxt_o.bank = b;
                        nxt_o.addr = col_addr(pend.col, pend.ap);
                        done_o     = 1'b1;
                    end
                end else begin
                    nxt_o.cmd  = CMD_PRE;
                    nxt_o.bank = b;
                end
            end else if (pre_ok_i[b]) begin
                nxt_o.cmd  = CMD_ACT;
                nxt_o.bank = b;
                nxt_o.addr = pend.row;
            end
        end
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdq_pkg::*;
#(
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_APRE = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_we,
    input  logic        req_ap,
    input  logic [1:0]  req_bank,
    input  logic [12:0] req_row,
    input  logic [9:0]  req_col,
    output logic [2:0]  cmd_o,
    output logic [1:0]  cmd_bank_o,
    output logic [12:0] cmd_addr_o
);

    logic                         pend_v;
    req_t                         pend_q;
    bus_t                         nxt;
    bus_t                         bus_q;
    logic                         done;
    logic [NBANK-1:0]             open_w;
    logic [NBANK-1:0][ROW_W-1:0]  row_w;
    logic [NBANK-1:0]             rcd_ok_w;
    logic [NBANK-1:0]             pre_ok_w;

    assign req_ready = !pend_v || done;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_q <= '0;
        end else if (req_valid && req_ready) begin
            pend_v <= 1'b1;
            pend_q <= '{we: req_we, ap: req_ap, bank: req_bank, row: req_row, col: req_col};
        end else if (done) begin
            pend_v <= 1'b0;
        end
    end

    sdq_cmd_pick u_pick (
        .pend_v   (pend_v),
        .pend     (pend_q),
        .open_i   (open_w),
        .row_i    (row_w),
        .rcd_ok_i (rcd_ok_w),
        .pre_ok_i (pre_ok_w),
        .nxt_o    (nxt),
        .done_o   (done)
    );

    sdq_bank_table #(.T_RCD(T_RCD), .T_RP(T_RP), .T_APRE(T_APRE)) u_tab (
        .clk         (clk),
        .rst         (rst),
        .ev_act      (nxt.cmd == CMD_ACT),
        .ev_pre      (nxt.cmd == CMD_PRE),
        .ev_close_ap (done && pend_q.ap),
        .ev_bank     (nxt.bank),
        .ev_row      (nxt.addr),
        .open_o      (open_w),
        .row_o       (row_w),
        .rcd_ok_o    (rcd_ok_w),
        .pre_ok_o    (pre_ok_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q <= '{cmd: CMD_NOP, bank: '0, addr: '0};
        end else begin
            bus_q <= nxt;
        end
    end

    assign cmd_o      = bus_q.cmd;
    assign cmd_bank_o = bus_q.bank;
    assign cmd_addr_o = bus_q.addr;

    // R3: an ACTIVE on the bus leaves its bank open on that row
    p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_q.cmd == CMD_ACT) |-> (open_w[bus_q.bank] && row_w[bus_q.bank] == bus_q.addr));

    // R5: a PRECHARGE on the bus leaves its bank closed
    p_pre_closes_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_q.cmd == CMD_PRE) |-> !open_w[bus_q.bank]);

    // R4: a plain column command leaves its row open
    p_col_keeps_open_r4: assert property (@(posedge clk) disable iff (rst)
        (is_col(bus_q.cmd) && !bus_q.addr[AP_BIT]) |-> open_w[bus_q.bank]);

    // R6: a column command with auto-precharge leaves its bank closed
    p_ap_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (is_col(bus_q.cmd) && bus_q.addr[AP_BIT]) |-> !open_w[bus_q.bank]);

    // R8: with nothing pending, the next bus cycle is NOP
    p_idle_nop_r8: assert property (@(posedge clk) disable iff (rst)
        !pend_v |=> (bus_q.cmd == CMD_NOP));

endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;

    localparam int T_RCD  = 3;
    localparam int T_RP   = 3;
    localparam int T_APRE = 5;

    typedef struct {
        logic [2:0]  cmd;
        logic [1:0]  bank;
        logic [12:0] addr;
        int          cyc;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic        req_ap = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [2:0]  cmd_o;
    logic [1:0]  cmd_bank_o;
    logic [12:0] cmd_addr_o;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    item_t q[$];

    bit    m_open[4];
    int    m_row[4];
    int    m_act[4];
    int    m_prerdy[4];
    int    last_col = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_APRE(T_APRE)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_ap(req_ap), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o)
    );

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(logic [2:0] c, logic [1:0] b, logic [12:0] a, int t, string tag);
        item_t it;
        it.cmd = c; it.bank = b; it.addr = a; it.cyc = t; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compares each bus command with the scoreboard head, cycle included
    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_o != 3'b111) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8", "unexpected command", int'(cmd_o), 7);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(cmd_o == it.cmd, it.tag, "command code", int'(cmd_o), int'(it.cmd));
                    check(cmd_bank_o == it.bank, it.tag, "bank", int'(cmd_bank_o), int'(it.bank));
                    check(cmd_addr_o == it.addr, it.tag, "address", int'(cmd_addr_o), int'(it.addr));
                    check(cyc == it.cyc, it.tag, "cycle", cyc, it.cyc);
                end
            end else if (q.size() > 0 && q[0].cyc <= cyc) begin
                item_t it;
                it = q.pop_front();
                check(1'b0, it.tag, "command missing (NOP seen, R8)", int'(cmd_o), int'(it.cmd));
            end
        end
    end

    // Driver: called just after a falling edge; returns just after the falling edge past acceptance
    task automatic send(bit we, bit ap, int b, int row, int col, string tag);
        int start, k, t, ta, tc;
        logic [12:0] ca;
        req_we = we; req_ap = ap; req_bank = 2'(b); req_row = 13'(row); req_col = 10'(col);
        req_valid = 1'b1;
        start = cyc;
        while (!req_ready) @(negedge clk);
        k = cyc + 1;
        check(k == imax(start + 1, last_col), "R9", "acceptance cycle", k, imax(start + 1, last_col));
        t = k + 1;
        if (m_open[b] && m_row[b] == row) begin
            tc = imax(t, m_act[b] + T_RCD);
        end else begin
            if (m_open[b]) begin
                push(3'b010, 2'(b), 13'd0, t, "R5");
                ta = t + T_RP;
            end else begin
                ta = imax(t, m_prerdy[b]);
            end
            push(3'b011, 2'(b), 13'(row), ta, tag);
            m_act[b] = ta;
            tc = ta + T_RCD;
        end
        ca = '0;
        ca[9:0] = 10'(col);
        ca[10] = ap;
        push(we ? 3'b100 : 3'b101, 2'(b), ca, tc, tag);
        last_col = tc;
        if (ap) begin
            m_open[b] = 1'b0;
            m_prerdy[b] = tc + T_APRE;
        end else begin
            m_open[b] = 1'b1;
            m_row[b] = row;
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 1'b0; m_row[i] = 0; m_act[i] = -100; m_prerdy[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(cmd_o == 3'b111, "R1", "cmd after reset", int'(cmd_o), 7);
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        idle(2);
        // R1/R3: closed bank, read (R2 encodings checked on every command)
        send(1'b0, 1'b0, 0, 5, 3, "R3");
        // R4: hits to the open row, back to back
        send(1'b1, 1'b0, 0, 5, 4, "R4");
        send(1'b0, 1'b0, 0, 5, 5, "R4");
        send(1'b1, 1'b0, 0, 5, 1023, "R4");
        idle(3);
        // R5: row miss in bank 0
        send(1'b0, 1'b0, 0, 13'h1ABC, 9, "R5");
        // R6: write with auto-precharge in bank 1
        send(1'b1, 1'b1, 1, 7, 1, "R6");
        // R7: hit in bank 0 while bank 1 precharges
        send(1'b0, 1'b0, 0, 13'h1ABC, 10, "R7");
        // R6: reopen bank 1, ACTIVE without PRECHARGE, held by T_APRE
        send(1'b0, 1'b0, 1, 7, 2, "R6");
        // R3: another closed bank, with a write
        send(1'b1, 1'b0, 3, 13'h1FFF, 0, "R3");
        idle(1);
        for (int i = 0; i < 200 && q.size() > 0; i++) @(negedge clk);
        check(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);
        // R8: quiet bus afterwards
        repeat (6) begin
            @(negedge clk);
            check(cmd_o == 3'b111, "R8", "idle NOP", int'(cmd_o), 7);
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not end", cyc, 0);
        finish_run();
    end

endmodule